// File: doc/BRIEF.md
# Outbound Address Translation Window

This block holds one programmable outbound translation window. Software loads six 32-bit address words and a control word through a simple indexed write port. Every lookup then presents a 64-bit untranslated address with a strobe. One cycle later the block reports whether the address falls inside the window. On a hit it returns the address moved into the target space, together with the transaction kind and the function number held in the control word.

The window's first address takes its upper half from the upper base word. Its last address always takes the low half from the limit word. The upper half of the last address comes from one of two places, chosen by the wide-window flag in the control word. With the flag clear it is the upper base word, and the upper limit word is ignored. With the flag set it is the upper limit word. A window that straddles a 4 GB boundary therefore decodes correctly only with the flag set. The flag should be set exactly when the upper 32 bits of (base + size − 1) are greater than the upper 32 bits of base. The testbench carries a reference function for this recommendation.

Addresses have a 64 KB granularity. The low 16 bits of base and target read as zeros, and the low 16 bits of the limit read as ones.

Top module: `atw_top`

## Requirements
- R1: Window start = {upper base word, lower base word} with bits 15:0 forced to zero.
- R2: With the wide flag (control bit 29) clear, window end = {upper base word, limit word} with bits 15:0 forced to one, and the upper limit word has no effect on matching.
- R3: With the wide flag set, window end = {upper limit word, limit word} with bits 15:0 forced to one.
- R4: A lookup hits only when the enable bit (control bit 31) is set and start ≤ address ≤ end, compared as unsigned 64-bit values. A window whose end is below its start never hits.
- R5: On a hit, out_addr = target + (address − start) modulo 2^64. The target is {upper target word, lower target word} with bits 15:0 forced to zero. On a miss, out_addr equals the untranslated address.
- R6: out_kind carries control bits 4:0 and out_func carries control bits 10:8, as they stood when the lookup was presented.
- R7: out_valid is in_valid delayed by exactly one clock, and out_hit is never high while out_valid is low.
- R8: Word indices are: 0 lower base, 1 upper base, 2 limit, 3 upper limit, 4 lower target, 5 upper target, 6 control; index 7 is ignored. A write is seen by lookups presented in later cycles. A lookup presented in the same cycle as a write uses the previous contents.
- R9: Synchronous reset clears every word, including enable, and drives out_valid and out_hit low.
- R10: For base 0x0_F0000000 with limit word 0x10000000, the end decodes to 0x0_1000FFFF with the flag clear (the window never hits) and to 0x1_1000FFFF with the flag set. For base 0xF0000000 and size 0x20000000, the recommended flag value is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_idx | input | 3 | Index of the word being written |
| cfg_wdata | input | 32 | Write data |
| in_valid | input | 1 | Lookup strobe |
| in_addr | input | 64 | Untranslated address |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| out_hit | output | 1 | Address fell inside the enabled window |
| out_addr | output | 64 | Translated address on hit, input address on miss |
| out_kind | output | 5 | Transaction kind from the control word |
| out_func | output | 3 | Function number from the control word |

## Verification
The hardest situation to reach is a window that crosses a 4 GB boundary. To reach it, the lower base must sit close to the top of a 4 GB page while the limit word wraps past zero. Uniform random values almost never produce that combination, and they almost never land addresses exactly on the end boundary. The stimulus therefore places the crossing example directly and checks both flag settings. Its random windows draw upper words from a tiny range and set lower words near page ends. Lookup addresses are then aimed at start−1, start, end and end+1, with a fraction of fully random addresses mixed in.

// File: rtl/atw_pkg.sv
package atw_pkg;
    localparam int ADDR_W    = 64;
    localparam int REG_W     = 32;
    localparam int GRAN_BITS = 16;
    localparam int KIND_W    = 5;
    localparam int FUNC_W    = 3;
    localparam int IDX_W     = 3;
    localparam int NUM_WORDS = 6;
    localparam int KIND_LSB  = 0;
    localparam int FUNC_LSB  = 8;
    localparam int WIDE_BIT  = 29;
    localparam int EN_BIT    = 31;

    localparam logic [ADDR_W-1:0] GRAN_MASK = ADDR_W'((64'd1 << GRAN_BITS) - 64'd1);

    typedef enum logic [IDX_W-1:0] {
        IDX_BASE_LO = 3'd0,
        IDX_BASE_HI = 3'd1,
        IDX_LIM_LO  = 3'd2,
        IDX_LIM_HI  = 3'd3,
        IDX_TGT_LO  = 3'd4,
        IDX_TGT_HI  = 3'd5,
        IDX_CTRL    = 3'd6
    } word_idx_e;

    typedef struct packed {
        logic              enable;
        logic              wide;
        logic [FUNC_W-1:0] func;
        logic [KIND_W-1:0] kind;
    } ctrl_t;

    typedef struct packed {
        logic [REG_W-1:0] base_lo;
        logic [REG_W-1:0] base_hi;
        logic [REG_W-1:0] lim_lo;
        logic [REG_W-1:0] lim_hi;
        logic [REG_W-1:0] tgt_lo;
        logic [REG_W-1:0] tgt_hi;
        ctrl_t            ctrl;
    } win_cfg_t;

    typedef struct packed {
        logic [ADDR_W-1:0] first;
        logic [ADDR_W-1:0] last;
        logic [ADDR_W-1:0] dest;
    } win_bounds_t;

    function automatic ctrl_t decode_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.enable = w[EN_BIT];
        c.wide   = w[WIDE_BIT];
        c.func   = w[FUNC_LSB +: FUNC_W];
        c.kind   = w[KIND_LSB +: KIND_W];
        return c;
    endfunction

    function automatic logic [ADDR_W-1:0] gran_floor(input logic [ADDR_W-1:0] a);
        return a & ~GRAN_MASK;
    endfunction

    function automatic logic [ADDR_W-1:0] gran_ceil(input logic [ADDR_W-1:0] a);
        return a | GRAN_MASK;
    endfunction
endpackage

// File: rtl/atw_regs.sv
module atw_regs
    import atw_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [REG_W-1:0] cfg_wdata,
    output win_cfg_t         cfg_o
);
    logic [REG_W-1:0] word_q [NUM_WORDS];
    ctrl_t            ctrl_q;

    for (genvar i = 0; i < NUM_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                word_q[i] <= '0;
            else if (cfg_we && cfg_idx == IDX_W'(i))
                word_q[i] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (cfg_we && cfg_idx == IDX_CTRL)
            ctrl_q <= decode_ctrl(cfg_wdata);
    end

    always_comb begin
        cfg_o.base_lo = word_q[IDX_BASE_LO];
        cfg_o.base_hi = word_q[IDX_BASE_HI];
        cfg_o.lim_lo  = word_q[IDX_LIM_LO];
        cfg_o.lim_hi  = word_q[IDX_LIM_HI];
        cfg_o.tgt_lo  = word_q[IDX_TGT_LO];
        cfg_o.tgt_hi  = word_q[IDX_TGT_HI];
        cfg_o.ctrl    = ctrl_q;
    end

    // R9: reset leaves the window disabled
    p_reset_disables_r9: assert property (@(posedge clk) rst |=> !cfg_o.ctrl.enable);

    // R8: a written base word is visible on the next cycle
    p_base_write_lands_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_idx == IDX_BASE_LO) |=> cfg_o.base_lo == $past(cfg_wdata));
endmodule

// File: rtl/atw_bounds.sv
module atw_bounds
    import atw_pkg::*;
(
    input  win_cfg_t    cfg_i,
    output win_bounds_t bnd_o
);
    logic [REG_W-1:0] last_hi;

    always_comb begin
        last_hi      = cfg_i.ctrl.wide ? cfg_i.lim_hi : cfg_i.base_hi;
        bnd_o.first  = gran_floor({cfg_i.base_hi, cfg_i.base_lo});
        bnd_o.last   = gran_ceil({last_hi, cfg_i.lim_lo});
        bnd_o.dest   = gran_floor({cfg_i.tgt_hi, cfg_i.tgt_lo});
    end
endmodule

// File: rtl/atw_xlate.sv
module atw_xlate
    import atw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    input  win_bounds_t       bnd_i,
    input  ctrl_t             ctrl_i,
    output logic              out_valid,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_addr,
    output logic [KIND_W-1:0] out_kind,
    output logic [FUNC_W-1:0] out_func
);
    logic              hit_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        hit_d  = ctrl_i.enable && (in_addr >= bnd_i.first) && (in_addr <= bnd_i.last);
        addr_d = hit_d ? bnd_i.dest + (in_addr - bnd_i.first) : in_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_addr  <= '0;
            out_kind  <= '0;
            out_func  <= '0;
        end else begin
            out_valid <= in_valid;
            out_hit   <= in_valid && hit_d;
            if (in_valid) begin
                out_addr <= addr_d;
                out_kind <= ctrl_i.kind;
                out_func <= ctrl_i.func;
            end
        end
    end

    // R7: one-cycle strobe pipeline
    p_valid_follows_r7: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid);
    p_idle_follows_r7:  assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid);
    p_hit_needs_valid_r7: assert property (@(posedge clk) disable iff (rst) out_hit |-> out_valid);
    // R4: disabled window never hits
    p_disabled_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !ctrl_i.enable) |=> !out_hit);
    // R4: inverted window never hits
    p_inverted_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && bnd_i.last < bnd_i.first) |=> !out_hit);
    // R5: a miss passes the address through
    p_miss_passthru_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !(ctrl_i.enable && in_addr >= bnd_i.first && in_addr <= bnd_i.last))
        |=> out_addr == $past(in_addr));
    // R6: kind field follows the control word
    p_kind_follows_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_kind == $past(ctrl_i.kind));
endmodule

// File: rtl/atw_top.sv
module atw_top
    import atw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic              out_hit,
    output logic [ADDR_W-1:0] out_addr,
    output logic [KIND_W-1:0] out_kind,
    output logic [FUNC_W-1:0] out_func
);
    win_cfg_t    cfg;
    win_bounds_t bnd;

    atw_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_idx   (cfg_idx),
        .cfg_wdata (cfg_wdata),
        .cfg_o     (cfg)
    );

    atw_bounds u_bounds (
        .cfg_i (cfg),
        .bnd_o (bnd)
    );

    atw_xlate u_xlate (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_addr   (in_addr),
        .bnd_i     (bnd),
        .ctrl_i    (cfg.ctrl),
        .out_valid (out_valid),
        .out_hit   (out_hit),
        .out_addr  (out_addr),
        .out_kind  (out_kind),
        .out_func  (out_func)
    );
endmodule

// File: tb/tb_atw_top.sv
`timescale 1ns/1ps
module tb_atw_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [63:0] in_addr = '0;
    logic        out_valid, out_hit;
    logic [63:0] out_addr;
    logic [4:0]  out_kind;
    logic [2:0]  out_func;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] sh [7];

    always #2 clk = ~clk;

    atw_top dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
        .in_valid(in_valid), .in_addr(in_addr), .out_valid(out_valid), .out_hit(out_hit),
        .out_addr(out_addr), .out_kind(out_kind), .out_func(out_func)
    );

    function automatic logic [63:0] m_start();
        return {sh[1], sh[0][31:16], 16'h0000};
    endfunction
    function automatic logic [63:0] m_end();
        return {(sh[6][29] ? sh[3] : sh[1]), sh[2][31:16], 16'hFFFF};
    endfunction
    function automatic bit m_hit(input logic [63:0] a);
        return sh[6][31] && (a >= m_start()) && (a <= m_end());
    endfunction
    function automatic logic [63:0] m_addr(input logic [63:0] a);
        if (m_hit(a)) return {sh[5], sh[4][31:16], 16'h0000} + (a - m_start());
        return a;
    endfunction
    function automatic bit want_wide(input logic [63:0] base, input logic [63:0] size);
        logic [63:0] lim;
        lim = base + size - 64'd1;
        return lim[63:32] > base[63:32];
    endfunction

    task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (idx < 7) sh[idx] = d;
    endtask

    task automatic window(input logic [63:0] base, input logic [63:0] lim,
                          input logic [63:0] tgt, input logic [31:0] ctrl);
        wr(0, base[31:0]); wr(1, base[63:32]);
        wr(2, lim[31:0]);  wr(3, lim[63:32]);
        wr(4, tgt[31:0]);  wr(5, tgt[63:32]);
        wr(6, ctrl);
    endtask

    task automatic look(input string req, input logic [63:0] a);
        @(negedge clk);
        in_valid = 1'b1; in_addr = a;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, "valid", 64'(out_valid), 64'd1);
        check(req, "hit", 64'(out_hit), 64'(m_hit(a)));
        check(req, "addr", out_addr, m_addr(a));
        check(req, "kind", 64'(out_kind), 64'(sh[6][4:0]));
        check(req, "func", 64'(out_func), 64'(sh[6][10:8]));
    endtask

    task automatic look_hit(input string req, input logic [63:0] a, input bit exp_hit);
        look(req, a);
        check(req, "directed hit", 64'(out_hit), 64'(exp_hit));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 7; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9: reset state
        check("R9", "out_valid after reset", 64'(out_valid), 64'd0);
        check("R9", "out_hit after reset", 64'(out_hit), 64'd0);
        look_hit("R9", 64'h0, 1'b0);
        // R7: idle cycle keeps valid low
        @(negedge clk);
        check("R7", "idle valid", 64'(out_valid), 64'd0);

        // R10: recommendation function
        check("R10", "want_wide crossing", 64'(want_wide(64'hF000_0000, 64'h2000_0000)), 64'd1);
        check("R10", "want_wide small", 64'(want_wide(64'h1000_0000, 64'h1000)), 64'd0);
        check("R10", "want_wide exact page end", 64'(want_wide(64'hFFFF_0000, 64'h1_0000)), 64'd0);
        check("R10", "want_wide one over", 64'(want_wide(64'hFFFF_0000, 64'h1_0001)), 64'd1);

        // R10 / R2: crossing window with flag clear -> end 0x0_1000FFFF, never hits
        window(64'h0_F000_0000, 64'h1_1000_0000, 64'h40_0000_0000, 32'h8000_0000);
        check("R10", "end flag clear", m_end(), 64'h0_1000_FFFF);
        look_hit("R10", 64'h0_F000_0000, 1'b0);
        look_hit("R10", 64'h1_0000_0000, 1'b0);
        look_hit("R10", 64'h0_1000_FFFF, 1'b0);
        // R10 / R3: flag set -> end 0x1_1000FFFF
        wr(6, 32'hA000_0000);
        check("R10", "end flag set", m_end(), 64'h1_1000_FFFF);
        look_hit("R10", 64'h0_F000_0000, 1'b1);
        look_hit("R3", 64'h1_1000_FFFF, 1'b1);
        look_hit("R3", 64'h1_1001_0000, 1'b0);
        look_hit("R4", 64'h0_EFFF_FFFF, 1'b0);
        check("R5", "crossing translation", m_addr(64'h1_1000_FFFF), 64'h40_2000_FFFF);

        // R2: upper limit word ignored when flag clear
        window(64'h2_0000_0000, 64'h7_0001_0000, 64'h0, 32'h8000_0000);
        look_hit("R2", 64'h2_0001_FFFF, 1'b1);
        look_hit("R2", 64'h7_0000_0000, 1'b0);
        look_hit("R2", 64'h2_0002_0000, 1'b0);

        // R1 / R6: granularity of base and target, fields
        window(64'h0_0001_2345, 64'h0_0003_0000, 64'h5_0000_ABCD, 32'h8000_0515);
        look_hit("R1", 64'h0_0001_0000, 1'b1);
        check("R1", "offset zero maps to target floor", out_addr, 64'h5_0000_0000);
        check("R6", "kind", 64'(out_kind), 64'h15);
        check("R6", "func", 64'(out_func), 64'h5);
        look_hit("R1", 64'h0_0000_FFFF, 1'b0);

        // R5: target wrap modulo 2^64
        window(64'h0, 64'h0_0003_0000, 64'hFFFF_FFFF_FFFF_0000, 32'h8000_0000);
        look_hit("R5", 64'h2_0000, 1'b1);
        check("R5", "wrapped address", out_addr, 64'h1_0000);

        // R8: same-cycle write uses old contents, later lookup sees new
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wdata = 32'h0;
        in_valid = 1'b1; in_addr = 64'h1_0000;
        @(negedge clk);
        cfg_we = 1'b0; in_valid = 1'b0;
        check("R8", "same-cycle lookup uses old enable", 64'(out_hit), 64'd1);
        sh[6] = 32'h0;
        look_hit("R8", 64'h1_0000, 1'b0);
        // R8: index 7 ignored
        wr(7, 32'hFFFF_FFFF);
        look_hit("R8", 64'h1_0000, 1'b0);

        // R4: inverted window never hits
        window(64'h3_0000_0000, 64'h2_FFFF_0000, 64'h0, 32'hA000_0000);
        look_hit("R4", 64'h3_0000_0000, 1'b0);
        look_hit("R4", 64'h2_FFFF_FFFF, 1'b0);

        // Random windows aimed at boundaries (R1-type checks via R4 model)
        for (int n = 0; n < 150; n++) begin
            logic [63:0] b, l, t, a;
            logic [31:0] c;
            b = {32'($urandom_range(0, 3)), ($urandom_range(0, 1) ? 32'hF000_0000 : 32'h0) | 32'($urandom)};
            l = {32'($urandom_range(0, 3)), 32'($urandom)};
            t = {32'($urandom), 32'($urandom)};
            c = 32'($urandom) & 32'h2000_071F;
            if ($urandom_range(0, 7) != 0) c[31] = 1'b1;
            window(b, l, t, c);
            for (int k = 0; k < 4; k++) begin
                case ($urandom_range(0, 4))
                    0: a = m_start() - 64'd1;
                    1: a = m_start();
                    2: a = m_end();
                    3: a = m_end() + 64'd1;
                    default: a = {32'($urandom_range(0, 3)), 32'($urandom)};
                endcase
                look("R4", a);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule